// File: doc/BRIEF.md
# Row-Hit-First Request Picker

This block chooses which entry of an ordered queue of pending memory requests should be issued next. Each queued entry carries a rank, a bank and a row. Entry 0 is the oldest, and only the first `rq_count` entries are live. The block also receives a table holding the currently open row of every bank. It has two policies. In arrival order it always takes the head of the queue. In row-hit-first order it takes the oldest live entry whose row is already open in its bank, and falls back to the head when no such entry exists. The choice is made combinationally. When the issuing logic accepts it, the choice is captured in a register.

The block has two more parts. A write-drain controller raises a drain burst when write-queue occupancy goes above a programmable threshold and reads are not being held off. The burst closes after threshold plus one writes have been issued, or earlier if the write queue empties. A forwarding matcher flags an incoming read whose address equals that of a pending write. Such a read can be answered from the write queue and never has to enter the read queue.

Top module: `rowhit_picker`

## Requirements
- R1: When `rq_count` is 0, `pick_valid` is low. When it is non-zero, `pick_valid` is high and `pick_idx` is below `rq_count`.
- R2: With `fr_mode` low (arrival order), `pick_idx` is 0 and `pick_hit` is low for every non-empty queue.
- R3: With `fr_mode` high and `rq_count` of 2 or more, `pick_idx` is the lowest live index whose bank has its open flag set and whose row equals that bank's open row, and `pick_hit` is high.
- R4: With `fr_mode` high and no live entry hitting an open row, `pick_idx` is 0 and `pick_hit` is low.
- R5: With exactly one live entry, `pick_idx` is 0 and `pick_hit` is low, even when that entry's row is open.
- R6: The open-row table entry for a request is `rank * 8 + bank`. Entry b of `ob_row` occupies bits [b*8 +: 8] and its flag is `ob_open[b]`. Queue entry i occupies [i*W +: W] of each `rq_*` vector. Entries at index `rq_count` or above never influence the pick.
- R7: In the cycle after `issue_take` is high while `pick_valid` is high, `issued_valid` is high and `issued_idx` equals the `pick_idx` of that cycle. After any other cycle, `issued_valid` is low.
- R8: While idle, the drain controller raises `drain_active` in the cycle after one in which `wq_count > wr_thresh` and `stop_reads` is low.
- R9: While `drain_active` is high, a cycle with `wq_count` equal to 0 ends the burst. Otherwise each `wr_issued` pulse is counted. The pulse that brings the count in this burst to `wr_thresh + 1` ends it. `drain_active` is low in the cycle after the ending cycle.
- R10: `rd_fwd` is high, combinationally, exactly when `rd_valid` is high and `rd_addr` equals `wq_addr` entry j for some j below `wq_count`. Entry j occupies bits [j*16 +: 16].
- R11: Reset is synchronous and active high. It clears `issued_valid` and `drain_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_mode | input | 1 | 1 = row-hit-first, 0 = arrival order |
| rq_count | input | 4 | Number of live queue entries |
| rq_rank | input | 8 | Rank field per entry, 1 bit each |
| rq_bank | input | 24 | Bank field per entry, 3 bits each |
| rq_row | input | 64 | Row field per entry, 8 bits each |
| ob_row | input | 128 | Open row per bank, 8 bits each |
| ob_open | input | 16 | Bank has an open row |
| issue_take | input | 1 | Issuing logic accepts the current pick |
| pick_valid | output | 1 | A pick exists |
| pick_idx | output | 3 | Chosen queue index |
| pick_hit | output | 1 | Chosen entry was selected as a row hit |
| issued_valid | output | 1 | Registered pick valid |
| issued_idx | output | 3 | Registered pick index |
| wq_count | input | 4 | Write-queue occupancy |
| wq_addr | input | 128 | Pending write addresses, 16 bits each |
| wr_thresh | input | 4 | Write-drain threshold |
| stop_reads | input | 1 | Reads held off; blocks a new drain |
| wr_issued | input | 1 | One write issued this cycle |
| drain_active | output | 1 | Drain burst in progress |
| rd_valid | input | 1 | Incoming read present |
| rd_addr | input | 16 | Incoming read address |
| rd_fwd | output | 1 | Read can be served from the write queue |

## Verification
The bench aims at the ordering corners of the picker. These are:
- several hits, where a wrong scan direction picks the youngest hit rather than the oldest;
- a hit that sits beyond `rq_count`, which a picker that ignores occupancy would take;
- a matching row in a bank whose open flag is clear;
- a single live entry, which must report no hit.

For the drain, it checks the exact pulse that closes a burst (threshold plus one, not threshold). It also checks that `stop_reads` blocks the start and that an emptied write queue cuts a burst short. An off-by-one in the burst counter shows up as a burst one write too short or too long. For forwarding, it places a matching address just past the live write entries, where a matcher that does not bound its scan would wrongly forward.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
    localparam int RANK_W         = 1;
    localparam int BANK_W         = 3;
    localparam int ROW_W          = 8;
    localparam int ADDR_W         = 16;
    localparam int BANKS_PER_RANK = 1 << BANK_W;
    localparam int NUM_BANKS      = (1 << RANK_W) * BANKS_PER_RANK;
    localparam int BIDX_W         = RANK_W + BANK_W;

    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } req_t;

    typedef enum logic {DR_IDLE, DR_BURST} drain_st_t;

    function automatic logic [BIDX_W-1:0] bank_index(
        input logic [RANK_W-1:0] r, input logic [BANK_W-1:0] b);
        return BIDX_W'(BIDX_W'(r) * BIDX_W'(BANKS_PER_RANK)) + BIDX_W'(b);
    endfunction
endpackage

// File: rtl/rhp_select.sv
module rhp_select
    import rhp_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int CNT_W  = $clog2(QDEPTH + 1),
    parameter int IDX_W  = $clog2(QDEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fr_mode,
    input  logic [CNT_W-1:0]  count,
    input  req_t              reqs     [QDEPTH],
    input  logic [ROW_W-1:0]  open_row [NUM_BANKS],
    input  logic [NUM_BANKS-1:0] open_vld,
    output logic              pick_valid,
    output logic [IDX_W-1:0]  pick_idx,
    output logic              pick_hit
);
    logic [QDEPTH-1:0] hit_vec;
    logic [IDX_W-1:0]  first_hit;
    logic              any_hit;

    for (genvar i = 0; i < QDEPTH; i++) begin : g_cmp
        logic [BIDX_W-1:0] bi;
        assign bi = bank_index(reqs[i].rank, reqs[i].bank);
        assign hit_vec[i] = (CNT_W'(i) < count) && open_vld[bi]
                            && (open_row[bi] == reqs[i].row);
    end

    always_comb begin
        first_hit = '0;
        any_hit   = 1'b0;
        for (int i = QDEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                first_hit = IDX_W'(i);
                any_hit   = 1'b1;
            end
        end
    end

    always_comb begin
        pick_valid = (count != '0);
        pick_idx   = '0;
        pick_hit   = 1'b0;
        if (fr_mode && (count > CNT_W'(1)) && any_hit) begin
            pick_idx = first_hit;
            pick_hit = 1'b1;
        end
    end

    // R1: chosen index always refers to a live entry
    assert_idx_live_R1: assert property (@(posedge clk) disable iff (rst)
        pick_valid |-> (CNT_W'(pick_idx) < count));

    // R2: arrival order always serves the head
    assert_fcfs_head_R2: assert property (@(posedge clk) disable iff (rst)
        (!fr_mode && pick_valid) |-> (pick_idx == '0 && !pick_hit));

    // R3: a reported hit really matches its bank's open row
    assert_hit_genuine_R3: assert property (@(posedge clk) disable iff (rst)
        pick_hit |-> (open_vld[bank_index(reqs[pick_idx].rank, reqs[pick_idx].bank)]
            && open_row[bank_index(reqs[pick_idx].rank, reqs[pick_idx].bank)]
               == reqs[pick_idx].row));
endmodule

// File: rtl/rhp_drain.sv
module rhp_drain
    import rhp_pkg::*;
#(
    parameter int WCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WCNT_W-1:0] wq_count,
    input  logic [WCNT_W-1:0] thresh,
    input  logic              stop_reads,
    input  logic              wr_issued,
    output logic              drain_active
);
    drain_st_t         st;
    logic [WCNT_W-1:0] burst_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= DR_IDLE;
            burst_n <= '0;
        end else begin
            case (st)
                DR_IDLE: begin
                    if (wq_count > thresh && !stop_reads) begin
                        st      <= DR_BURST;
                        burst_n <= '0;
                    end
                end
                default: begin
                    if (wq_count == '0) begin
                        st <= DR_IDLE;
                    end else if (wr_issued) begin
                        if (burst_n >= thresh) st <= DR_IDLE;
                        else burst_n <= burst_n + 1'b1;
                    end
                end
            endcase
        end
    end

    assign drain_active = (st == DR_BURST);

    // R8: a burst starts only from an over-threshold, reads-allowed cycle
    assert_start_cond_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_active) |-> $past(wq_count > thresh && !stop_reads));

    // R9: a burst ends only on an issued write or an empty write queue
    assert_end_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(drain_active) |-> $past(wr_issued || wq_count == '0));
endmodule

// File: rtl/rhp_fwd.sv
module rhp_fwd
    import rhp_pkg::*;
#(
    parameter int WQ_DEPTH = 8,
    parameter int WCNT_W   = $clog2(WQ_DEPTH + 1)
) (
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wq_addr [WQ_DEPTH],
    input  logic [WCNT_W-1:0] wq_count,
    output logic              rd_fwd
);
    logic [WQ_DEPTH-1:0] match;

    for (genvar j = 0; j < WQ_DEPTH; j++) begin : g_m
        assign match[j] = (WCNT_W'(j) < wq_count) && (wq_addr[j] == rd_addr);
    end

    assign rd_fwd = rd_valid && (|match);
endmodule

// File: rtl/rowhit_picker.sv
module rowhit_picker
    import rhp_pkg::*;
#(
    parameter int QDEPTH   = 8,
    parameter int WQ_DEPTH = 8,
    localparam int CNT_W   = $clog2(QDEPTH + 1),
    localparam int IDX_W   = $clog2(QDEPTH),
    localparam int WCNT_W  = $clog2(WQ_DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fr_mode,
    input  logic [CNT_W-1:0]            rq_count,
    input  logic [QDEPTH*RANK_W-1:0]    rq_rank,
    input  logic [QDEPTH*BANK_W-1:0]    rq_bank,
    input  logic [QDEPTH*ROW_W-1:0]     rq_row,
    input  logic [NUM_BANKS*ROW_W-1:0]  ob_row,
    input  logic [NUM_BANKS-1:0]        ob_open,
    input  logic                        issue_take,
    output logic                        pick_valid,
    output logic [IDX_W-1:0]            pick_idx,
    output logic                        pick_hit,
    output logic                        issued_valid,
    output logic [IDX_W-1:0]            issued_idx,
    input  logic [WCNT_W-1:0]           wq_count,
    input  logic [WQ_DEPTH*ADDR_W-1:0]  wq_addr,
    input  logic [WCNT_W-1:0]           wr_thresh,
    input  logic                        stop_reads,
    input  logic                        wr_issued,
    output logic                        drain_active,
    input  logic                        rd_valid,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic                        rd_fwd
);
    req_t              reqs     [QDEPTH];
    logic [ROW_W-1:0]  open_row [NUM_BANKS];
    logic [ADDR_W-1:0] waddr    [WQ_DEPTH];

    for (genvar i = 0; i < QDEPTH; i++) begin : g_req
        assign reqs[i].rank = rq_rank[i*RANK_W +: RANK_W];
        assign reqs[i].bank = rq_bank[i*BANK_W +: BANK_W];
        assign reqs[i].row  = rq_row[i*ROW_W +: ROW_W];
    end
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign open_row[b] = ob_row[b*ROW_W +: ROW_W];
    end
    for (genvar j = 0; j < WQ_DEPTH; j++) begin : g_wq
        assign waddr[j] = wq_addr[j*ADDR_W +: ADDR_W];
    end

    rhp_select #(.QDEPTH(QDEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_sel (
        .clk(clk), .rst(rst), .fr_mode(fr_mode), .count(rq_count),
        .reqs(reqs), .open_row(open_row), .open_vld(ob_open),
        .pick_valid(pick_valid), .pick_idx(pick_idx), .pick_hit(pick_hit)
    );

    rhp_drain #(.WCNT_W(WCNT_W)) i_drain (
        .clk(clk), .rst(rst), .wq_count(wq_count), .thresh(wr_thresh),
        .stop_reads(stop_reads), .wr_issued(wr_issued),
        .drain_active(drain_active)
    );

    rhp_fwd #(.WQ_DEPTH(WQ_DEPTH), .WCNT_W(WCNT_W)) i_fwd (
        .rd_valid(rd_valid), .rd_addr(rd_addr), .wq_addr(waddr),
        .wq_count(wq_count), .rd_fwd(rd_fwd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            issued_valid <= 1'b0;
            issued_idx   <= '0;
        end else begin
            issued_valid <= issue_take && pick_valid;
            if (issue_take && pick_valid) issued_idx <= pick_idx;
        end
    end

    // R7: an accepted pick appears in the issue register one cycle later
    assert_issue_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_take && pick_valid) |=> (issued_valid && issued_idx == $past(pick_idx)));
endmodule

// File: tb/test_rowhit_picker.sv
module test_rowhit_picker;
    localparam int CLK_PERIOD = 10;
    localparam int QD = 8;
    localparam int WD = 8;
    localparam int NB = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        fr_mode = 0, issue_take = 0, stop_reads = 0, wr_issued = 0, rd_valid = 0;
    logic [3:0]  rq_count = 0, wq_count = 0, wr_thresh = 0;
    logic [15:0] rd_addr = 0;
    logic [0:0]  a_rank [QD];
    logic [2:0]  a_bank [QD];
    logic [7:0]  a_row  [QD];
    logic [7:0]  a_orow [NB];
    logic [NB-1:0] ob_open = 0;
    logic [15:0] a_wa   [WD];

    logic [QD-1:0]    rq_rank;
    logic [QD*3-1:0]  rq_bank;
    logic [QD*8-1:0]  rq_row;
    logic [NB*8-1:0]  ob_row;
    logic [WD*16-1:0] wq_addr;

    always_comb begin
        for (int i = 0; i < QD; i++) begin
            rq_rank[i] = a_rank[i][0];
            rq_bank[i*3 +: 3] = a_bank[i];
            rq_row[i*8 +: 8] = a_row[i];
        end
        for (int b = 0; b < NB; b++) ob_row[b*8 +: 8] = a_orow[b];
        for (int j = 0; j < WD; j++) wq_addr[j*16 +: 16] = a_wa[j];
    end

    logic       pick_valid, pick_hit, issued_valid, drain_active, rd_fwd;
    logic [2:0] pick_idx, issued_idx;

    rowhit_picker i_rowhit_picker (
        .clk(clk), .rst(rst), .fr_mode(fr_mode), .rq_count(rq_count),
        .rq_rank(rq_rank), .rq_bank(rq_bank), .rq_row(rq_row),
        .ob_row(ob_row), .ob_open(ob_open), .issue_take(issue_take),
        .pick_valid(pick_valid), .pick_idx(pick_idx), .pick_hit(pick_hit),
        .issued_valid(issued_valid), .issued_idx(issued_idx),
        .wq_count(wq_count), .wq_addr(wq_addr), .wr_thresh(wr_thresh),
        .stop_reads(stop_reads), .wr_issued(wr_issued),
        .drain_active(drain_active), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_fwd(rd_fwd)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference: pick by scanning the live entries
    function automatic void ref_pick(output bit v, output int idx, output bit h,
                                     output string tag);
        int first;
        v = (rq_count != 0); idx = 0; h = 0; first = -1;
        for (int i = 0; i < int'(rq_count); i++) begin
            int b;
            b = int'(a_rank[i]) * 8 + int'(a_bank[i]);   // R6 bank index
            if (first < 0 && ob_open[b] && a_orow[b] == a_row[i]) first = i;
        end
        if (!v)                      tag = "R1";
        else if (!fr_mode)           tag = "R2";
        else if (rq_count == 1)      tag = "R5";
        else if (first < 0)          tag = "R4 R6";
        else begin tag = "R3 R6"; idx = first; h = 1; end
    endfunction

    function automatic bit ref_fwd();
        bit f = 0;
        for (int j = 0; j < int'(wq_count); j++) if (a_wa[j] == rd_addr) f = 1;
        return rd_valid && f;
    endfunction

    bit m_iv = 0; int m_ii = 0;
    bit m_dr = 0; int m_n = 0;

    always @(posedge clk) begin
        bit v, h; int idx; string t;
        ref_pick(v, idx, h, t);
        if (rst) begin
            m_iv <= 0; m_dr <= 0; m_n <= 0;
        end else begin
            m_iv <= issue_take && v;
            if (issue_take && v) m_ii <= idx;
            if (!m_dr) begin
                if (wq_count > wr_thresh && !stop_reads) begin m_dr <= 1; m_n <= 0; end
            end else if (wq_count == 0) m_dr <= 0;
            else if (wr_issued) begin
                if (m_n >= int'(wr_thresh)) m_dr <= 0; else m_n <= m_n + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit v, h; int idx; string t;
        if (!done) begin
            ref_pick(v, idx, h, t);
            chk(t, "pick_valid", pick_valid, v);
            if (v) begin
                chk(t, "pick_idx", pick_idx, idx);
                chk(t, "pick_hit", pick_hit, h);
            end
            chk(rst ? "R11" : "R7", "issued_valid", issued_valid, m_iv);
            if (m_iv) chk("R7", "issued_idx", issued_idx, m_ii);
            chk(rst ? "R11" : "R8 R9", "drain_active", drain_active, m_dr);
            chk("R10", "rd_fwd", rd_fwd, ref_fwd());
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic clear_q();
        for (int i = 0; i < QD; i++) begin a_rank[i] = 0; a_bank[i] = 0; a_row[i] = 8'hF0 + 8'(i); end
        for (int b = 0; b < NB; b++) a_orow[b] = 0;
        for (int j = 0; j < WD; j++) a_wa[j] = 16'hFF00 + 16'(j);
        ob_open = '1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        clear_q();
        // R11: reset state with drain conditions present
        wq_count = 5; wr_thresh = 1; issue_take = 1; rq_count = 2;
        repeat (3) tick();
        rst = 0; issue_take = 0; wq_count = 0; rq_count = 0;
        tick(); tick();
        // R1: empty queue
        fr_mode = 1; tick();
        // R2: arrival order ignores a hit at index 2
        rq_count = 3; fr_mode = 0; a_row[2] = 0; tick();
        // R3: two hits (2 and 3), oldest wins
        fr_mode = 1; a_row[3] = 0; tick();
        issue_take = 1; tick(); issue_take = 0; tick();   // R7 capture
        // R4: no hit, head chosen
        a_row[2] = 8'h11; a_row[3] = 8'h22; tick();
        // R6: hit beyond count ignored
        a_row[5] = 0; tick();
        // R6: bank index rank*8+bank, closed bank ignored
        a_rank[1] = 1; a_bank[1] = 3; a_row[1] = 8'h5A; a_orow[11] = 8'h5A; tick();
        ob_open[11] = 0; tick(); ob_open[11] = 1;
        // R5: single live entry that hits
        rq_count = 1; a_row[0] = 0; tick();
        // R8/R9: burst of thresh+1 writes
        wr_thresh = 2; wq_count = 3; tick();
        wq_count = 2; tick();
        wr_issued = 1; repeat (3) tick(); wr_issued = 0; tick();
        // R8: stop_reads blocks the start
        stop_reads = 1; wq_count = 6; repeat (2) tick();
        stop_reads = 0; tick(); tick();
        // R9: empty write queue cuts burst short
        wq_count = 0; tick(); tick();
        // R10: forwarding inside and beyond the live window
        rd_valid = 1; wq_count = 2; a_wa[1] = 16'h1234; rd_addr = 16'h1234; tick();
        a_wa[1] = 0; a_wa[2] = 16'h1234; tick();
        rd_valid = 0; a_wa[0] = 16'h1234; tick();
        // random traffic
        for (int k = 0; k < 3000; k++) begin
            fr_mode = ($urandom_range(0, 3) != 0);
            rq_count = 4'($urandom_range(0, QD));
            for (int i = 0; i < QD; i++) begin
                a_rank[i] = 1'($urandom_range(0, 1));
                a_bank[i] = 3'($urandom_range(0, 1));
                a_row[i]  = 8'($urandom_range(0, 3));
            end
            for (int b = 0; b < NB; b++) a_orow[b] = 8'($urandom_range(0, 3));
            ob_open = 16'($urandom);
            issue_take = 1'($urandom_range(0, 1));
            if (k % 17 == 0) wr_thresh = 4'($urandom_range(0, 6));
            wq_count = 4'($urandom_range(0, WD));
            stop_reads = ($urandom_range(0, 7) == 0);
            wr_issued = 1'($urandom_range(0, 1));
            rd_valid = 1'($urandom_range(0, 1));
            rd_addr = 16'($urandom_range(0, 15));
            for (int j = 0; j < WD; j++) a_wa[j] = 16'($urandom_range(0, 15));
            tick();
        end
        tick();
        finish_run();
    end
endmodule